// File: doc/BRIEF.md
# Serial Chain Upset Tester

This block fills a device with one long serial shift chain and checks every bit that leaves the chain, so that single-event upsets can be counted while the device is under a particle beam. The chain is a series of equal-length segments joined end to end. A generator feeds the head of the chain with either a pseudo-random bitstream or a fixed repeating word. The bits leaving the far end are compared with a second, identical generator on chip. That second generator starts advancing only after the chain has been completely filled, so it lags the first by exactly the chain length.

Every mismatch produces a one-cycle pulse and increments a saturating error counter. A separate wide counter records how many bits have been checked, so that the error rate per bit can be calculated afterwards. A run enable pauses and resumes the whole test without losing state. The block is meant to run at clock rates up to 40 MHz, and it is re-run at several clock rates to look for frequency dependence.

Top module: `seu_chain_tester`

## Requirements
- R1: While reset (`rst_n` low) is active, and right after it, `serial_out`, `mismatch`, `err_count`, `bit_count` and `armed` are all zero, and the chain holds only zeros.
- R2: The chain latency L is SEG_LEN*NUM_SEG run cycles. `serial_out` equals the bit injected L run cycles earlier, and reads 0 until L run cycles have passed.
- R3: With `mode_sel`=0 the injected bit is bit 30 of a 31-bit state that starts at SEED. On each run cycle the state moves to {s[29:0], s[30]^s[27]}.
- R4: With `mode_sel`=1 the injected bit on run cycle n is bit (PAT_W-1-(n mod PAT_W)) of PATTERN. That is the top bit of the word rotated left once per run cycle.
- R5: `armed` rises after exactly L run cycles since reset and then stays high. No bit is checked or counted before that.
- R6: On each run cycle with `armed` high, `serial_out` is compared with a regenerated bit. That bit is taken from the source that `mode_sel` selects in that cycle, at the index L run cycles back. `mismatch` is high in the next cycle if and only if the two bits differ.
- R7: `err_count` rises by one for each mismatch and stops at all ones. Only reset clears it.
- R8: `bit_count` rises by one for each checked run cycle.
- R9: While `run_en` is low, the chain, both generators, `armed` and all counters hold their values, and `mismatch` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | High: shift, generate and check; low: pause |
| mode_sel | input | 1 | 0 = pseudo-random source, 1 = fixed rotating pattern |
| serial_out | output | 1 | Bit leaving the end of the chain |
| mismatch | output | 1 | One-cycle pulse for a checked bit that differed |
| err_count | output | ERR_W | Saturating mismatch count |
| bit_count | output | BIT_W | Number of bits checked |
| armed | output | 1 | Chain full, checking active |

## Verification
The assertions assume that `run_en` and `mode_sel` are synchronous to `clk` and stable around each rising edge. They also assume that reset is asserted at the start before any check applies. The bench changes both inputs only at falling edges and starts with reset held. `mode_sel` may change in any cycle. Flipping it while the chain still holds bits from the other source is how the bench creates known mismatches, because the block has no fault input. Short segments keep the chain latency small, and a narrow error counter lets saturation be reached within the run.

// File: rtl/seu_pkg.sv
package seu_pkg;
  localparam int unsigned PRBS_W = 31;

  typedef enum logic {
    SRC_PRBS    = 1'b0,
    SRC_PATTERN = 1'b1
  } src_mode_e;

  // one step of the x^31 + x^28 + 1 generator, shift toward the msb
  function automatic logic [PRBS_W-1:0] prbs31_step(input logic [PRBS_W-1:0] s);
    return {s[PRBS_W-2:0], s[30] ^ s[27]};
  endfunction
endpackage

// File: rtl/seu_stream_gen.sv
module seu_stream_gen
  import seu_pkg::*;
#(
  parameter int unsigned       PAT_W   = 32,
  parameter logic [PAT_W-1:0]  PATTERN = 32'hC3A5_0FF1,
  parameter logic [PRBS_W-1:0] SEED    = 31'h2BAD_1E55
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic mode,
  output logic bit_o
);
  logic [PRBS_W-1:0] prbs_q;
  logic [PAT_W-1:0]  pat_q;
  src_mode_e         sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prbs_q <= SEED;
      pat_q  <= PATTERN;
    end else if (adv) begin
      prbs_q <= prbs31_step(prbs_q);
      pat_q  <= {pat_q[PAT_W-2:0], pat_q[PAT_W-1]};
    end
  end

  assign sel   = src_mode_e'(mode);
  assign bit_o = (sel == SRC_PATTERN) ? pat_q[PAT_W-1] : prbs_q[PRBS_W-1];
endmodule

// File: rtl/seu_shift_segment.sv
module seu_shift_segment #(
  parameter int unsigned LEN = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic dout
);
  logic [LEN-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sr_q <= '0;
    else if (en) sr_q <= {sr_q[LEN-2:0], din};
  end

  assign dout = sr_q[LEN-1];
endmodule

// File: rtl/seu_error_tally.sv
module seu_error_tally #(
  parameter int unsigned ERR_W = 32,
  parameter int unsigned BIT_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             check,
  input  logic             diff,
  output logic             mismatch_o,
  output logic [ERR_W-1:0] err_o,
  output logic [BIT_W-1:0] bits_o
);
  logic hit;
  assign hit = check & diff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mismatch_o <= 1'b0;
      err_o      <= '0;
      bits_o     <= '0;
    end else begin
      mismatch_o <= hit;
      if (hit && (err_o != {ERR_W{1'b1}})) err_o <= err_o + 1'b1;
      if (check) bits_o <= bits_o + 1'b1;
    end
  end
endmodule

// File: rtl/seu_chain_tester.sv
module seu_chain_tester
  import seu_pkg::*;
#(
  parameter int unsigned       SEG_LEN = 512,
  parameter int unsigned       NUM_SEG = 38,
  parameter int unsigned       PAT_W   = 32,
  parameter logic [PAT_W-1:0]  PATTERN = 32'hC3A5_0FF1,
  parameter logic [PRBS_W-1:0] SEED    = 31'h2BAD_1E55,
  parameter int unsigned       ERR_W   = 32,
  parameter int unsigned       BIT_W   = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             mode_sel,
  output logic             serial_out,
  output logic             mismatch,
  output logic [ERR_W-1:0] err_count,
  output logic [BIT_W-1:0] bit_count,
  output logic             armed
);
  localparam int unsigned CHAIN_LEN = SEG_LEN * NUM_SEG;
  localparam int unsigned FILL_W    = $clog2(CHAIN_LEN + 1);
  localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(CHAIN_LEN - 1);

  logic              inj_bit;
  logic              exp_bit;
  logic              check_fire;
  logic              cmp_diff;
  logic [FILL_W-1:0] fill_q;
  logic              armed_q;
  logic [NUM_SEG:0]  link;

  // fill tracking: armed after CHAIN_LEN run cycles
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q  <= '0;
      armed_q <= 1'b0;
    end else if (run_en && !armed_q) begin
      fill_q <= fill_q + 1'b1;
      if (fill_q == FILL_LAST) armed_q <= 1'b1;
    end
  end

  seu_stream_gen #(.PAT_W(PAT_W), .PATTERN(PATTERN), .SEED(SEED)) inj_gen_i (
    .clk(clk), .rst_n(rst_n), .adv(run_en), .mode(mode_sel), .bit_o(inj_bit)
  );

  seu_stream_gen #(.PAT_W(PAT_W), .PATTERN(PATTERN), .SEED(SEED)) exp_gen_i (
    .clk(clk), .rst_n(rst_n), .adv(run_en & armed_q), .mode(mode_sel), .bit_o(exp_bit)
  );

  assign link[0] = inj_bit;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    seu_shift_segment #(.LEN(SEG_LEN)) seg_i (
      .clk(clk), .rst_n(rst_n), .en(run_en), .din(link[g]), .dout(link[g+1])
    );
  end

  assign serial_out = link[NUM_SEG];
  assign check_fire = run_en & armed_q;
  assign cmp_diff   = serial_out ^ exp_bit;
  assign armed      = armed_q;

  seu_error_tally #(.ERR_W(ERR_W), .BIT_W(BIT_W)) tally_i (
    .clk(clk), .rst_n(rst_n), .check(check_fire), .diff(cmp_diff),
    .mismatch_o(mismatch), .err_o(err_count), .bits_o(bit_count)
  );
endmodule

// File: rtl/seu_chain_tester_chk.sv
module seu_chain_tester_chk #(
  parameter int unsigned ERR_W = 32,
  parameter int unsigned BIT_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             serial_out,
  input logic             mismatch,
  input logic [ERR_W-1:0] err_count,
  input logic [BIT_W-1:0] bit_count,
  input logic             armed,
  input logic             check_fire,
  input logic             cmp_diff
);
  // R7
  err_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> err_count >= $past(err_count));

  // R7
  err_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&err_count) |=> (&err_count));

  // R6
  mism_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (check_fire && cmp_diff) |=> mismatch);

  // R6
  mism_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(check_fire && cmp_diff) |=> !mismatch);

  // R5
  arm_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> (bit_count == $past(bit_count)) && !mismatch);

  // R5
  arm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);

  // R8
  bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    check_fire |=> bit_count == $past(bit_count) + 1'b1);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> $stable(serial_out) && $stable(bit_count) && $stable(err_count)
                && $stable(armed) && !mismatch);
endmodule

bind seu_chain_tester seu_chain_tester_chk #(.ERR_W(ERR_W), .BIT_W(BIT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .serial_out(serial_out),
  .mismatch(mismatch), .err_count(err_count), .bit_count(bit_count),
  .armed(armed), .check_fire(check_fire), .cmp_diff(cmp_diff)
);

// File: tb/seu_chain_tester_tb.sv
module seu_chain_tester_tb_top;
  localparam int unsigned SEG_LEN = 16;
  localparam int unsigned NUM_SEG = 4;
  localparam int unsigned L       = SEG_LEN * NUM_SEG;
  localparam int unsigned PAT_W   = 32;
  localparam logic [31:0] PATTERN = 32'hC3A5_0FF1;
  localparam logic [30:0] SEED    = 31'h2BAD_1E55;
  localparam int unsigned ERR_W   = 6;
  localparam int unsigned BIT_W   = 48;
  localparam int unsigned HMAX    = 8192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0;
  logic mode_sel = 1'b0;
  logic             serial_out;
  logic             mismatch;
  logic [ERR_W-1:0] err_count;
  logic [BIT_W-1:0] bit_count;
  logic             armed;

  always #5 clk = ~clk;

  seu_chain_tester #(
    .SEG_LEN(SEG_LEN), .NUM_SEG(NUM_SEG), .PAT_W(PAT_W), .PATTERN(PATTERN),
    .SEED(SEED), .ERR_W(ERR_W), .BIT_W(BIT_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode_sel(mode_sel),
    .serial_out(serial_out), .mismatch(mismatch), .err_count(err_count),
    .bit_count(bit_count), .armed(armed)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // bench model state
  bit          inj_hist  [HMAX];
  bit          prbs_hist [HMAX];
  bit          mode_hist [HMAX];
  int unsigned runs;
  int unsigned prbs_st;
  bit          m_mism;
  int unsigned m_err;
  longint unsigned m_bits;

  function automatic bit pat_at(int unsigned idx);
    return PATTERN[PAT_W - 1 - (idx % PAT_W)];
  endfunction

  function automatic int unsigned prbs_adv(int unsigned s);
    int unsigned fb;
    fb = ((s >> 30) ^ (s >> 27)) & 1;
    return ((s << 1) | fb) & 32'h7FFF_FFFF;
  endfunction

  task automatic model_reset();
    runs = 0; prbs_st = 32'(SEED); m_mism = 0; m_err = 0; m_bits = 0;
  endtask

  task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (run %0d)", req, act, exp, runs);
    end
  endtask

  task automatic check_outputs(input bit paused);
    bit exp_out;
    string oreq;
    exp_out = (runs >= L) ? inj_hist[runs - L] : 1'b0;
    oreq = (runs < L) ? "R2" : (mode_hist[runs - L] ? "R4" : "R3");
    if (paused) oreq = "R9";
    chk(oreq, serial_out, exp_out);
    chk(paused ? "R9" : "R6", mismatch, m_mism);
    chk(paused ? "R9" : "R7", err_count, m_err);
    chk(paused ? "R9" : "R8", bit_count, m_bits);
    chk("R5", armed, runs >= L);
  endtask

  task automatic step(input bit r, input bit m);
    @(negedge clk);
    run_en = r; mode_sel = m;
    m_mism = 0;
    if (r) begin
      prbs_hist[runs] = prbs_st[30];
      mode_hist[runs] = m;
      inj_hist[runs]  = m ? pat_at(runs) : prbs_st[30];
      prbs_st = prbs_adv(prbs_st);
      if (runs >= L) begin
        bit e;
        e = m ? pat_at(runs - L) : prbs_hist[runs - L];
        m_mism = (e != inj_hist[runs - L]);
        if (m_mism && m_err < (1 << ERR_W) - 1) m_err++;
        m_bits++;
      end
      runs++;
    end
    @(posedge clk);
    #1;
    check_outputs(!r);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; run_en = 0; mode_sel = 0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", {serial_out, mismatch, armed}, 0);
    chk("R1", err_count, 0);
    chk("R1", bit_count, 0);
    rst_n = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1..all actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R2/R3: fill in PRBS mode, no pauses, then R5 arming edge
    for (int i = 0; i < L + 40; i++) step(1, 0);
    // R9: directed pause
    for (int i = 0; i < 12; i++) step(0, 0);
    // random run/pause, PRBS only: R6 no errors expected
    for (int i = 0; i < 300; i++) step(($urandom % 5) != 0, 0);
    chk("R7", err_count, 0);
    // R4/R6: switch to pattern mode; chain still holds PRBS bits
    for (int i = 0; i < 2 * L; i++) step(($urandom % 4) != 0, 1);
    // random mode flips, drives R7 to saturation
    for (int i = 0; i < 1200; i++) begin
      bit mm;
      mm = (($urandom % 40) == 0) ? ~mode_sel : mode_sel;
      step(($urandom % 6) != 0, mm);
    end
    // R7: saturated and held
    chk("R7", err_count, (1 << ERR_W) - 1);
    // R1: reset clears everything, then R4 fill from reset in pattern mode
    do_reset();
    for (int i = 0; i < L + 100; i++) step(1, 1);
    chk("R7", err_count, 0);
    for (int i = 0; i < 200; i++) step(($urandom % 3) != 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule